// File: doc/BRIEF.md
# Tick-Driven Down-Count Timer Bank

This block holds a small array of identical countdown timers. Each one is clocked by the system clock but counts only on a single-cycle tick pulse, typically one per microsecond. Software programs a channel by writing one word that carries an enable flag, a mode flag and a count. The channel then counts down on each tick and raises a level interrupt when the count is spent. In single-shot mode it then switches itself off. In repeating mode it reloads its programmed count and goes on.

The count uses an off-by-one encoding: a programmed count of N gives an interrupt on the (N+1)-th tick after the write. Software therefore writes the wanted number of ticks minus one, and zero for a single tick. The interrupt stays asserted until software writes a clear bit into the channel's second register. Reading that register returns the live count and the pending flag. Each channel takes an 8-byte window of address space: the control word at offset 0 and the status/clear word at offset 4.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every channel is disabled, its count and programmed value read zero and every `irq` bit is low.
- R2: Channel c is decoded at byte address 8*c. Address bit 2 selects the control word (0) or the status word (1), and address bits 1:0 are ignored. Writes to a channel index of NUM_CH or above change nothing, and reads there return zero.
- R3: Control word layout: bit 31 enable, bit 30 repeating mode, bits 28:0 count N. Reading it returns the stored enable, mode and N, with every other bit zero.
- R4: An enabled channel programmed with N raises its `irq` bit on exactly the (N+1)-th tick after the write. Each earlier tick lowers the count by one.
- R5: Reading the status word returns the live count in bits 28:0 and the pending interrupt in bit 30, with every other bit zero.
- R6: In single-shot mode (bit 30 = 0), expiry clears the enable bit and leaves the count at zero. Later ticks raise no further interrupt.
- R7: In repeating mode (bit 30 = 1), expiry reloads N and keeps the channel enabled, so it expires every N+1 ticks.
- R8: `irq` is an active-high level that stays high until a status-word write with bit 30 = 1. A status write with bit 30 = 0 leaves it unchanged.
- R9: When an expiry and a clear fall in the same cycle, the expiry wins and `irq` stays high.
- R10: A write of zero to the control word stops the channel. While disabled, ticks leave the count unchanged.
- R11: A control-word write reloads the count with the new N at once. A tick in the same cycle as that write is ignored, so the new N+1 tick span starts at the next tick.
- R12: Channels run independently. Programming, ticking and clearing one channel leave the state of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle count pulse shared by all channels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | NUM_CH | Level interrupt, one bit per channel |

## Verification
The bench builds the bank with three channels and an 8-bit address. This gives a third channel whose index has its upper address bit set, and an unpopulated fourth window at 0x18 on which the ignored-access rules can be checked. The full 29-bit count is kept, so the largest count can be written and read back. Expiry itself is timed with short counts, where the exact N+1 tick span, the reload and the clear-versus-expiry race finish in a few dozen cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W      = 32;
    localparam int CNT_FIELD_W = 29;
    localparam int EN_BIT      = 31;
    localparam int MODE_BIT    = 30;
    localparam int CLR_BIT     = 30;
    localparam int PEND_BIT    = 30;

    typedef enum logic {
        REG_CTRL   = 1'b0,
        REG_STATUS = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic rep;
    } mode_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(
        input mode_t                  m,
        input logic [CNT_FIELD_W-1:0] cnt
    );
        logic [DATA_W-1:0] w;
        w = '0;
        w[EN_BIT]            = m.en;
        w[MODE_BIT]          = m.rep;
        w[CNT_FIELD_W-1:0]   = cnt;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(
        input logic                   pend,
        input logic [CNT_FIELD_W-1:0] cnt
    );
        logic [DATA_W-1:0] w;
        w = '0;
        w[PEND_BIT]          = pend;
        w[CNT_FIELD_W-1:0]   = cnt;
        return w;
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              wr,
    input  logic [ADDR_W-1:2] addr_hi,
    output logic [NUM_CH-1:0] sel,
    output logic [NUM_CH-1:0] wr_ctrl,
    output logic [NUM_CH-1:0] wr_status,
    output reg_sel_e          rsel
);
    localparam int CH_W = ADDR_W - 3;

    logic [CH_W-1:0] ch_idx;

    assign ch_idx = addr_hi[ADDR_W-1:3];
    assign rsel   = reg_sel_e'(addr_hi[2]);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        assign sel[c]       = (ch_idx == CH_W'(c));
        assign wr_ctrl[c]   = wr && sel[c] && (rsel == REG_CTRL);
        assign wr_status[c] = wr && sel[c] && (rsel == REG_STATUS);
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_ctrl,
    input  logic             wr_status,
    input  logic             w_en,
    input  logic             w_rep,
    input  logic             w_clr,
    input  logic [CNT_W-1:0] w_cnt,
    output mode_t            mode_q,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq_q
);
    logic expire;
    logic at_zero;

    assign at_zero = (cnt_q == '0);
    assign expire  = tick && mode_q.en && at_zero && !wr_ctrl;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            reload_q <= '0;
            cnt_q    <= '0;
        end else if (wr_ctrl) begin
            mode_q.en  <= w_en;
            mode_q.rep <= w_rep;
            reload_q   <= w_cnt;
            cnt_q      <= w_cnt;
        end else if (tick && mode_q.en) begin
            if (at_zero) begin
                if (mode_q.rep) begin
                    cnt_q <= reload_q;
                end else begin
                    mode_q.en <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (expire) begin
            irq_q <= 1'b1;
        end else if (wr_status && w_clr) begin
            irq_q <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 29
) (
    input  logic [NUM_CH-1:0]            sel,
    input  reg_sel_e                     rsel,
    input  logic [NUM_CH-1:0]            en_v,
    input  logic [NUM_CH-1:0]            rep_v,
    input  logic [NUM_CH-1:0]            irq_v,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_v,
    input  logic [NUM_CH-1:0][CNT_W-1:0] reload_v,
    output logic [DATA_W-1:0]            rdata
);
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel[c]) begin
                if (rsel == REG_CTRL) begin
                    rdata = pack_ctrl('{en: en_v[c], rep: rep_v[c]},
                                      CNT_FIELD_W'(reload_v[c]));
                end else begin
                    rdata = pack_status(irq_v[c], CNT_FIELD_W'(cnt_v[c]));
                end
            end
        end
    end

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 29
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0]            sel_v;
    logic [NUM_CH-1:0]            wr_ctrl_v;
    logic [NUM_CH-1:0]            wr_status_v;
    reg_sel_e                     rsel;
    logic [NUM_CH-1:0]            en_v;
    logic [NUM_CH-1:0]            rep_v;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_v;
    logic [NUM_CH-1:0][CNT_W-1:0] reload_v;
    logic [CNT_W-1:0]             w_cnt;
    logic                         w_en;
    logic                         w_rep;
    logic                         w_clr;
    logic                         spare_bits_unused;

    assign w_cnt = bus_wdata[CNT_W-1:0];
    assign w_en  = bus_wdata[EN_BIT];
    assign w_rep = bus_wdata[MODE_BIT];
    assign w_clr = bus_wdata[CLR_BIT];
    assign spare_bits_unused = ^{bus_wdata[29:CNT_W], bus_addr[1:0]};

    tmr_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .wr        (bus_wr),
        .addr_hi   (bus_addr[ADDR_W-1:2]),
        .sel       (sel_v),
        .wr_ctrl   (wr_ctrl_v),
        .wr_status (wr_status_v),
        .rsel      (rsel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        mode_t m;

        tmr_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .wr_ctrl   (wr_ctrl_v[c]),
            .wr_status (wr_status_v[c]),
            .w_en      (w_en),
            .w_rep     (w_rep),
            .w_clr     (w_clr),
            .w_cnt     (w_cnt),
            .mode_q    (m),
            .reload_q  (reload_v[c]),
            .cnt_q     (cnt_v[c]),
            .irq_q     (irq[c])
        );

        assign en_v[c]  = m.en;
        assign rep_v[c] = m.rep;
    end

    tmr_rdmux #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W)
    ) u_rdmux (
        .sel      (sel_v),
        .rsel     (rsel),
        .en_v     (en_v),
        .rep_v    (rep_v),
        .irq_v    (irq),
        .cnt_v    (cnt_v),
        .reload_v (reload_v),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 29
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         tick,
    input logic [NUM_CH-1:0]            wr_ctrl_v,
    input logic [NUM_CH-1:0]            wr_status_v,
    input logic                         w_en,
    input logic                         w_clr,
    input logic [CNT_W-1:0]             w_cnt,
    input logic [NUM_CH-1:0]            en_v,
    input logic [NUM_CH-1:0]            rep_v,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_v,
    input logic [NUM_CH-1:0][CNT_W-1:0] reload_v,
    input logic [NUM_CH-1:0]            irq
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq == '0) && (en_v == '0)); // R1

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_DOWNCOUNT: assert property (@(posedge clk) disable iff (rst)
            en_v[c] && tick && (cnt_v[c] != '0) && !wr_ctrl_v[c]
            |=> cnt_v[c] == CNT_W'($past(cnt_v[c]) - 1'b1)); // R4

        AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
            en_v[c] && !rep_v[c] && tick && (cnt_v[c] == '0) && !wr_ctrl_v[c]
            |=> !en_v[c] && irq[c] && (cnt_v[c] == '0)); // R6

        AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (rst)
            en_v[c] && rep_v[c] && tick && (cnt_v[c] == '0) && !wr_ctrl_v[c]
            |=> en_v[c] && irq[c] && (cnt_v[c] == $past(reload_v[c]))); // R7

        AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
            irq[c] && !(wr_status_v[c] && w_clr) |=> irq[c]); // R8

        AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (rst)
            wr_status_v[c] && w_clr
            && !(en_v[c] && tick && (cnt_v[c] == '0) && !wr_ctrl_v[c])
            |=> !irq[c]); // R9

        AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
            !en_v[c] && !wr_ctrl_v[c] |=> $stable(cnt_v[c])); // R10

        AST_RESTART: assert property (@(posedge clk) disable iff (rst)
            wr_ctrl_v[c] |=> (cnt_v[c] == $past(w_cnt)) && (en_v[c] == $past(w_en))); // R11
    end

endmodule

bind tick_timer_bank tmr_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .wr_ctrl_v   (wr_ctrl_v),
    .wr_status_v (wr_status_v),
    .w_en        (w_en),
    .w_clr       (w_clr),
    .w_cnt       (w_cnt),
    .en_v        (en_v),
    .rep_v       (rep_v),
    .cnt_v       (cnt_v),
    .reload_v    (reload_v),
    .irq         (irq)
);

// File: tb/tick_timer_bank_tb_top.sv
module tick_timer_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 3;
    localparam int AW         = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           tick = 1'b0;
    logic           bus_wr = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] irq;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer_bank #(
        .NUM_CH (NCH),
        .ADDR_W (AW),
        .CNT_W  (29)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic [1:0] ch;
        logic       rep;
        logic [7:0] n;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{ch: 2'd0, rep: 1'b0, n: 8'd0},
        '{ch: 2'd1, rep: 1'b0, n: 8'd1},
        '{ch: 2'd2, rep: 1'b0, n: 8'd5},
        '{ch: 2'd0, rep: 1'b1, n: 8'd3},
        '{ch: 2'd1, rep: 1'b1, n: 8'd0},
        '{ch: 2'd2, rep: 1'b1, n: 8'd12}
    };

    function automatic logic [AW-1:0] ctrl_a(input int ch);
        return AW'(ch * 8);
    endfunction

    function automatic logic [AW-1:0] stat_a(input int ch);
        return AW'(ch * 8 + 4);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_tick(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks_to_fire(input int ch, input int limit, output int k);
        k = 0;
        while (k < limit) begin
            pulse();
            k++;
            if (irq[ch]) break;
        end
    endtask

    task automatic quiesce();
        for (int c = 0; c < NCH; c++) begin
            wr(ctrl_a(c), 32'h0);
            wr(stat_a(c), 32'h4000_0000);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int k;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 irq", 32'(irq), 32'h0);
        rd(ctrl_a(0), d); chk("R1 ctrl ch0", d, 32'h0);
        rd(stat_a(2), d); chk("R1 status ch2", d, 32'h0);

        // R4 R6 R7: vector table of expiry spans
        for (int i = 0; i < 6; i++) begin
            int ch;
            int n;
            ch = int'(VECS[i].ch);
            n  = int'(VECS[i].n);
            wr(ctrl_a(ch), {1'b1, VECS[i].rep, 1'b0, 29'(n)});
            ticks_to_fire(ch, n + 4, k);
            chk("R4 ticks to expiry", 32'(k), 32'(n + 1));
            if (VECS[i].rep) begin
                wr(stat_a(ch), 32'h4000_0000);
                ticks_to_fire(ch, n + 4, k);
                chk("R7 repeat span", 32'(k), 32'(n + 1));
                rd(ctrl_a(ch), d);
                chk("R7 still enabled", d, {2'b11, 1'b0, 29'(n)});
            end else begin
                rd(ctrl_a(ch), d);
                chk("R6 enable self-cleared", d, {3'b000, 29'(n)});
            end
            quiesce();
        end

        // R3 R5: layout and readback with the largest count
        wr(ctrl_a(1), 32'hFFFF_FFFF);
        rd(ctrl_a(1), d); chk("R3 ctrl readback", d, 32'hDFFF_FFFF);
        rd(stat_a(1), d); chk("R5 status count", d, 32'h1FFF_FFFF);
        pulse();
        rd(stat_a(1), d); chk("R5 status after tick", d, 32'h1FFF_FFFE);
        quiesce();

        // R6: single shot stays quiet after clear
        wr(ctrl_a(0), 32'h8000_0001);
        ticks_to_fire(0, 6, k);
        wr(stat_a(0), 32'h4000_0000);
        repeat (5) pulse();
        chk("R6 no re-fire", 32'(irq), 32'h0);
        rd(stat_a(0), d); chk("R6 count held zero", d, 32'h0);

        // R8: level holds, bit30=0 write does not clear
        wr(ctrl_a(1), 32'hC000_0000);
        pulse();
        wr(ctrl_a(1), 32'h0);
        wr(stat_a(1), 32'hBFFF_FFFF);
        chk("R8 irq held", 32'(irq[1]), 32'h1);
        rd(stat_a(1), d); chk("R8 pending bit", d, 32'h4000_0000);
        wr(stat_a(1), 32'h4000_0000);
        chk("R8 irq cleared", 32'(irq[1]), 32'h0);

        // R9: clear and expiry in the same cycle
        wr(ctrl_a(2), 32'hC000_0000);
        pulse();
        wr_tick(stat_a(2), 32'h4000_0000);
        chk("R9 expiry wins", 32'(irq[2]), 32'h1);
        quiesce();

        // R10: stop and frozen count
        wr(ctrl_a(0), 32'h8000_0005);
        repeat (2) pulse();
        wr(ctrl_a(0), 32'h0);
        repeat (7) pulse();
        chk("R10 stopped no irq", 32'(irq[0]), 32'h0);
        rd(stat_a(0), d); chk("R10 stopped count", d, 32'h0);
        wr(ctrl_a(0), 32'h0000_0007);
        repeat (4) pulse();
        rd(stat_a(0), d); chk("R10 disabled count frozen", d, 32'h7);
        quiesce();

        // R11: restart while running, simultaneous tick ignored
        wr(ctrl_a(0), 32'h8000_000A);
        repeat (3) pulse();
        rd(stat_a(0), d); chk("R11 running count", d, 32'h7);
        wr_tick(ctrl_a(0), 32'h8000_0002);
        rd(stat_a(0), d); chk("R11 reloaded count", d, 32'h2);
        ticks_to_fire(0, 8, k);
        chk("R11 new span", 32'(k), 32'h3);
        quiesce();

        // R2: address decode
        wr(8'h09, 32'h8000_0004);
        rd(8'h08, d); chk("R2 low bits ignored", d, 32'h8000_0004);
        rd(8'h0E, d); chk("R2 status via offset 6", d, 32'h0000_0004);
        wr(8'h18, 32'hC000_0003);
        rd(8'h18, d); chk("R2 unpopulated ctrl", d, 32'h0);
        rd(8'h1C, d); chk("R2 unpopulated status", d, 32'h0);
        rd(8'h00, d); chk("R2 ch0 untouched", d, 32'h0);
        rd(8'h10, d); chk("R2 ch2 untouched", d, 32'h0);
        quiesce();

        // R12: independent channels
        wr(ctrl_a(0), 32'h8000_0002);
        wr(ctrl_a(2), 32'h8000_0004);
        repeat (3) pulse();
        chk("R12 ch0 only", 32'(irq), 32'h1);
        rd(stat_a(2), d); chk("R12 ch2 count", d, 32'h1);
        wr(stat_a(0), 32'h4000_0000);
        repeat (2) pulse();
        chk("R12 ch2 fires alone", 32'(irq), 32'h4);
        rd(ctrl_a(1), d); chk("R12 ch1 idle", d, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule